// File: doc/BRIEF.md
# Offset-Matrix Colour Space Converter

This block converts a stream of three-component pixels from one colour space to another on its way to an on-screen-display output. For each pixel it adds a signed offset to each 10-bit component, multiplies the resulting vector by a 3x3 matrix of signed fixed-point coefficients, rounds the sums back to integer scale, adds a second signed offset per channel and clamps each result to the 10-bit range. A typical setting turns full-range RGB into limited-range BT.709 YCbCr: zero pre-offsets, the rounded BT.709 luma and chroma weights, and post-offsets of 64, 512 and 512.

Coefficients, offsets and an enable bit are written through a simple word-wide write port into a shadow copy. The shadow copy becomes the working set only at a frame-start pulse, so a frame is never processed with a half-updated matrix. When the enable bit of the working set is clear, pixels travel through the same pipeline unchanged. Every pixel leaves the block a fixed number of cycles after it enters, with its valid flag delayed to match.

Top module: `csc_osd_top`

## Requirements
- R1: After reset the output valid is low and the working set is all zero with the enable clear, so pixels pass through unchanged until a set is loaded.
- R2: Bit 0 of the control register (address 9) enables conversion; while the working enable is clear, out_pix equals in_pix bit for bit (channel 0 in bits 9:0, channel 1 in 19:10, channel 2 in 29:20).
- R3: Before the matrix, each channel adds its own 12-bit two's-complement pre-offset; address 0 holds channel 0 in bits 27:16 and channel 1 in bits 11:0, address 1 holds channel 2 in bits 11:0.
- R4: Coefficients are 13-bit two's-complement values with 1024 meaning unity gain; output k is the sum over j of coef[k][j] times offset input j. Addresses 2 to 5 hold the pairs 00/01, 02/10, 11/12, 20/21 with the first of each pair in bits 28:16 and the second in bits 12:0; coefficient 22 sits in bits 28:16 of address 6.
- R5: Each matrix sum is rounded by adding 512 and shifting right arithmetically by 10, so exact halves round towards plus infinity.
- R6: After rounding, each channel adds its own 12-bit two's-complement post-offset; address 7 holds channel 0 in bits 27:16 and channel 1 in bits 11:0, address 8 holds channel 2 in bits 11:0.
- R7: Each converted output is clamped to 0..1023.
- R8: A pixel accepted at a clock edge appears on the output after exactly three edges, with gaps in the input valid reproduced unchanged and no pixel lost or duplicated.
- R9: Register writes land in a shadow set and change nothing at the output until a frame_start pulse, which copies the shadow set as it stood before that edge into the working set.
- R10: Bits outside the listed fields, and writes to addresses 10 to 15, have no effect on the conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| frame_start | input | 1 | Pulse that loads the shadow set into the working set |
| in_valid | input | 1 | Input pixel valid |
| in_pix | input | 30 | Input pixel, three 10-bit components |
| out_valid | output | 1 | Output pixel valid |
| out_pix | output | 30 | Output pixel, three 10-bit components |

## Verification
The bench builds the block with its default widths: 10-bit components and 10 fractional coefficient bits, which with 13-bit coefficients and 12-bit offsets give gains from -4.0 to just under 4.0. With those values a gain of 2.0 on a bright input drives the sum well past 1023 and a large negative pre-offset drives it below zero, so both clamp bounds are reached, and single-unit inputs against half-gain coefficients land exactly on the rounding midpoint in both signs. A scoreboard also tracks the cycle each result is due, so the three-cycle latency is checked on back-to-back and gapped traffic alike.

// File: rtl/csc_pkg.sv
package csc_pkg;

    // Field widths fixed by the register layout
    localparam int CSC_COEF_W = 13;
    localparam int CSC_OFF_W  = 12;
    localparam int CSC_CH     = 3;
    localparam int CSC_TAPS   = CSC_CH * CSC_CH;
    localparam int HI_LSB     = 16;
    localparam int LO_LSB     = 0;

    typedef enum logic [3:0] {
        REG_PRE_01   = 4'd0,
        REG_PRE_2    = 4'd1,
        REG_K_00_01  = 4'd2,
        REG_K_02_10  = 4'd3,
        REG_K_11_12  = 4'd4,
        REG_K_20_21  = 4'd5,
        REG_K_22     = 4'd6,
        REG_POST_01  = 4'd7,
        REG_POST_2   = 4'd8,
        REG_CTRL     = 4'd9
    } csc_reg_e;

    typedef struct packed {
        logic                                 en;
        logic [CSC_CH-1:0][CSC_OFF_W-1:0]     pre;
        logic [CSC_TAPS-1:0][CSC_COEF_W-1:0]  coef;
        logic [CSC_CH-1:0][CSC_OFF_W-1:0]     post;
    } csc_cfg_t;

endpackage

// File: rtl/csc_cfg_regs.sv
module csc_cfg_regs
    import csc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic [3:0]  addr,
    input  logic [31:0] wdata,
    input  logic        frame_start,
    output csc_cfg_t    shd_cfg,
    output csc_cfg_t    act_cfg
);

    logic unused_bits;
    assign unused_bits = ^{wdata[31:HI_LSB+CSC_COEF_W], wdata[HI_LSB-1:CSC_COEF_W]};

    always_ff @(posedge clk) begin
        if (rst) begin
            shd_cfg <= '0;
            act_cfg <= '0;
        end else begin
            if (we) begin
                case (csc_reg_e'(addr))
                    REG_PRE_01: begin
                        shd_cfg.pre[0] <= wdata[HI_LSB +: CSC_OFF_W];
                        shd_cfg.pre[1] <= wdata[LO_LSB +: CSC_OFF_W];
                    end
                    REG_PRE_2:   shd_cfg.pre[2]  <= wdata[LO_LSB +: CSC_OFF_W];
                    REG_K_22:    shd_cfg.coef[8] <= wdata[HI_LSB +: CSC_COEF_W];
                    REG_POST_01: begin
                        shd_cfg.post[0] <= wdata[HI_LSB +: CSC_OFF_W];
                        shd_cfg.post[1] <= wdata[LO_LSB +: CSC_OFF_W];
                    end
                    REG_POST_2:  shd_cfg.post[2] <= wdata[LO_LSB +: CSC_OFF_W];
                    REG_CTRL:    shd_cfg.en      <= wdata[0];
                    default: ;
                endcase
                // Coefficient pairs in row-major order
                for (int p = 0; p < 4; p++) begin
                    if (addr == 4'(int'(REG_K_00_01) + p)) begin
                        shd_cfg.coef[2*p]   <= wdata[HI_LSB +: CSC_COEF_W];
                        shd_cfg.coef[2*p+1] <= wdata[LO_LSB +: CSC_COEF_W];
                    end
                end
            end
            if (frame_start) begin
                act_cfg <= shd_cfg;
            end
        end
    end

endmodule

// File: rtl/csc_pipe.sv
module csc_pipe
    import csc_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int FRAC_W = 10
) (
    input  logic                     clk,
    input  logic                     rst,
    input  csc_cfg_t                 cfg,
    input  logic                     in_valid,
    input  logic [CSC_CH*DATA_W-1:0] in_pix,
    output logic                     out_valid,
    output logic [CSC_CH*DATA_W-1:0] out_pix
);

    localparam int PIX_W = CSC_CH * DATA_W;
    localparam int S_W   = ((DATA_W + 1 > CSC_OFF_W) ? DATA_W + 1 : CSC_OFF_W) + 1;
    localparam int P_W   = S_W + CSC_COEF_W;
    localparam int A_W   = P_W + 2;
    localparam logic signed [A_W-1:0] RND  = A_W'(1) <<< (FRAC_W - 1);
    localparam logic signed [A_W-1:0] MAXV = A_W'((1 << DATA_W) - 1);

    // Stage 1: pre-offset
    logic                          v1, en1;
    logic [PIX_W-1:0]              raw1;
    logic signed [S_W-1:0]         s1 [CSC_CH];
    // Stage 2: products
    logic                          v2, en2;
    logic [PIX_W-1:0]              raw2;
    logic signed [P_W-1:0]         p2 [CSC_TAPS];
    // Stage 3 combinational result
    logic [PIX_W-1:0]              conv;

    always_ff @(posedge clk) begin
        if (rst) begin
            v1 <= 1'b0; en1 <= 1'b0; raw1 <= '0;
            v2 <= 1'b0; en2 <= 1'b0; raw2 <= '0;
            out_valid <= 1'b0; out_pix <= '0;
        end else begin
            v1 <= in_valid; en1 <= cfg.en; raw1 <= in_pix;
            v2 <= v1;       en2 <= en1;    raw2 <= raw1;
            out_valid <= v2;
            out_pix   <= en2 ? conv : raw2;
        end
    end

    for (genvar ch = 0; ch < CSC_CH; ch++) begin : g_pre
        logic signed [S_W-1:0] pix_s, off_s;
        assign pix_s = S_W'($signed({1'b0, in_pix[ch*DATA_W +: DATA_W]}));
        assign off_s = S_W'($signed(cfg.pre[ch]));
        always_ff @(posedge clk) begin
            if (rst) s1[ch] <= '0;
            else     s1[ch] <= pix_s + off_s;
        end
    end

    for (genvar k = 0; k < CSC_TAPS; k++) begin : g_mul
        logic signed [P_W-1:0] a_x, c_x;
        assign a_x = P_W'(s1[k % CSC_CH]);
        assign c_x = P_W'($signed(cfg.coef[k]));
        always_ff @(posedge clk) begin
            if (rst) p2[k] <= '0;
            else     p2[k] <= a_x * c_x;
        end
    end

    for (genvar r = 0; r < CSC_CH; r++) begin : g_row
        logic signed [A_W-1:0] acc, rnd, y;
        always_comb begin
            acc = A_W'(p2[r*CSC_CH]) + A_W'(p2[r*CSC_CH+1])
                + A_W'(p2[r*CSC_CH+2]) + RND;
            rnd = acc >>> FRAC_W;
            y   = rnd + A_W'($signed(cfg.post[r]));
            if (y < 0)
                conv[r*DATA_W +: DATA_W] = '0;
            else if (y > MAXV)
                conv[r*DATA_W +: DATA_W] = '1;
            else
                conv[r*DATA_W +: DATA_W] = y[DATA_W-1:0];
        end
    end

endmodule

// File: rtl/csc_osd_top.sv
module csc_osd_top
    import csc_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int FRAC_W = 10
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_we,
    input  logic [3:0]               cfg_addr,
    input  logic [31:0]              cfg_wdata,
    input  logic                     frame_start,
    input  logic                     in_valid,
    input  logic [CSC_CH*DATA_W-1:0] in_pix,
    output logic                     out_valid,
    output logic [CSC_CH*DATA_W-1:0] out_pix
);

    csc_cfg_t shd_cfg;
    csc_cfg_t act_cfg;

    csc_cfg_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .we          (cfg_we),
        .addr        (cfg_addr),
        .wdata       (cfg_wdata),
        .frame_start (frame_start),
        .shd_cfg     (shd_cfg),
        .act_cfg     (act_cfg)
    );

    csc_pipe #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_pipe (
        .clk       (clk),
        .rst       (rst),
        .cfg       (act_cfg),
        .in_valid  (in_valid),
        .in_pix    (in_pix),
        .out_valid (out_valid),
        .out_pix   (out_pix)
    );

endmodule

// File: rtl/csc_osd_chk.sv
module csc_osd_chk
    import csc_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     frame_start,
    input logic                     in_valid,
    input logic [CSC_CH*DATA_W-1:0] in_pix,
    input logic                     out_valid,
    input logic [CSC_CH*DATA_W-1:0] out_pix,
    input csc_cfg_t                 shd_cfg,
    input csc_cfg_t                 act_cfg
);

    logic [1:0] cyc;
    always_ff @(posedge clk) begin
        if (rst)            cyc <= '0;
        else if (cyc != 2'd3) cyc <= cyc + 2'd1;
    end

    // R1: reset empties the pipeline
    a_r1_reset_quiet: assert property (@(posedge clk) rst |=> !out_valid);

    // R8: valid emerges three edges after it enters
    a_r8_latency: assert property (@(posedge clk) disable iff (rst)
        (cyc == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    // R2: with the working enable clear the pixel is unchanged
    a_r2_bypass: assert property (@(posedge clk) disable iff (rst)
        (cyc == 2'd3 && out_valid && !$past(act_cfg.en, 3))
            |-> (out_pix == $past(in_pix, 3)));

    // R9: working set only moves on frame_start
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (cyc != 2'd0 && !frame_start) |=> $stable(act_cfg));

    // R9: frame_start takes the shadow set from before the edge
    a_r9_load: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (act_cfg == $past(shd_cfg)));

endmodule

bind csc_osd_top csc_osd_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .in_valid    (in_valid),
    .in_pix      (in_pix),
    .out_valid   (out_valid),
    .out_pix     (out_pix),
    .shd_cfg     (shd_cfg),
    .act_cfg     (act_cfg)
);

// File: tb/csc_osd_top_test.sv
module csc_osd_top_test;

    localparam int DW = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        frame_start = 1'b0;
    logic        in_valid = 1'b0;
    logic [29:0] in_pix = '0;
    logic        out_valid;
    logic [29:0] out_pix;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    csc_osd_top uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .frame_start(frame_start),
        .in_valid(in_valid), .in_pix(in_pix),
        .out_valid(out_valid), .out_pix(out_pix)
    );

    // Bench model of the shadow and working sets
    int s_coef[9], s_pre[3], s_post[3]; bit s_en;
    int a_coef[9], a_pre[3], a_post[3]; bit a_en;

    typedef struct { logic [29:0] pix; int due; string tag; } item_t;
    item_t sb[$];

    function automatic int sx(input int v, input int w);
        int m = v & ((1 << w) - 1);
        return (m >= (1 << (w - 1))) ? m - (1 << w) : m;
    endfunction

    function automatic logic [29:0] model(input logic [29:0] p);
        logic [29:0] r;
        int s[3];
        if (!a_en) return p;
        for (int j = 0; j < 3; j++) s[j] = int'(p[j*DW +: DW]) + a_pre[j];
        for (int k = 0; k < 3; k++) begin
            int acc, y;
            acc = a_coef[k*3]*s[0] + a_coef[k*3+1]*s[1] + a_coef[k*3+2]*s[2];
            y = ((acc + 512) >>> 10) + a_post[k];
            if (y < 0) y = 0;
            if (y > 1023) y = 1023;
            r[k*DW +: DW] = 10'(y);
        end
        return r;
    endfunction

    function automatic logic [29:0] px(input int c0, input int c1, input int c2);
        return {10'(c2), 10'(c1), 10'(c0)};
    endfunction

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        case (a)
            4'd0: begin s_pre[0] = sx(int'(d[27:16]), 12); s_pre[1] = sx(int'(d[11:0]), 12); end
            4'd1: s_pre[2] = sx(int'(d[11:0]), 12);
            4'd2, 4'd3, 4'd4, 4'd5: begin
                s_coef[(a-2)*2]   = sx(int'(d[28:16]), 13);
                s_coef[(a-2)*2+1] = sx(int'(d[12:0]), 13);
            end
            4'd6: s_coef[8] = sx(int'(d[28:16]), 13);
            4'd7: begin s_post[0] = sx(int'(d[27:16]), 12); s_post[1] = sx(int'(d[11:0]), 12); end
            4'd8: s_post[2] = sx(int'(d[11:0]), 12);
            4'd9: s_en = d[0];
            default: ;
        endcase
    endtask

    task automatic fstart();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        a_coef = s_coef; a_pre = s_pre; a_post = s_post; a_en = s_en;
    endtask

    task automatic load(input int c[9], input int pr[3], input int po[3],
                        input bit en, input bit junk);
        logic [31:0] j13, j12;
        j13 = junk ? 32'hE000_E000 : 32'h0;
        j12 = junk ? 32'hF000_F000 : 32'h0;
        wr(4'd0, j12 | {4'h0, 12'(pr[0]), 4'h0, 12'(pr[1])});
        wr(4'd1, j12 | {20'h0, 12'(pr[2])});
        for (int p = 0; p < 4; p++)
            wr(4'(2 + p), j13 | {3'b0, 13'(c[2*p]), 3'b0, 13'(c[2*p+1])});
        wr(4'd6, j13 | {3'b0, 13'(c[8]), 16'h0});
        wr(4'd7, j12 | {4'h0, 12'(po[0]), 4'h0, 12'(po[1])});
        wr(4'd8, j12 | {20'h0, 12'(po[2])});
        wr(4'd9, (junk ? 32'hFFFF_FFFE : 32'h0) | {31'h0, en});
        if (junk) begin
            // R10: addresses beyond the map must not disturb anything
            wr(4'd12, 32'hFFFF_FFFF);
            wr(4'd15, 32'h1234_5678);
        end
    endtask

    task automatic send(input logic [29:0] p, input string tag);
        item_t it;
        @(negedge clk);
        in_valid = 1'b1; in_pix = p;
        it.pix = model(p); it.due = cyc + 3; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0; in_pix = '0;
        end
    endtask

    // Monitor: pops and compares as results come out
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL R8: unexpected output %h, expected none", out_pix);
            end else begin
                item_t it;
                it = sb.pop_front();
                if (out_pix !== it.pix) begin
                    errors++;
                    $display("FAIL %s: pix got %h exp %h", it.tag, out_pix, it.pix);
                end
                checks++;
                if (cyc != it.due) begin
                    errors++;
                    $display("FAIL R8: output cycle got %0d exp %0d", cyc, it.due);
                end
            end
        end
    end

    function automatic int cn(input real g);
        return $rtoi((g * 2048.0 + 1.0) / 2.0);
    endfunction

    initial begin
        int c[9], pr[3], po[3];
        for (int i = 0; i < 9; i++) begin s_coef[i] = 0; a_coef[i] = 0; end
        for (int i = 0; i < 3; i++) begin s_pre[i] = 0; s_post[i] = 0; a_pre[i] = 0; a_post[i] = 0; end
        s_en = 0; a_en = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: out_valid got %b exp 0", out_valid);
        end
        send(px(1, 512, 1023), "R1");
        send(px(0, 0, 0), "R1");
        idle(5);

        // R9: identity plus pre-offset, enabled, but no frame_start yet
        c = '{1024, 0, 0, 0, 1024, 0, 0, 0, 1024};
        pr = '{5, -3, 0}; po = '{0, 0, 0};
        load(c, pr, po, 1'b1, 1'b0);
        send(px(100, 200, 300), "R9");
        send(px(1023, 0, 7), "R9");
        idle(5);

        // R3: now it takes effect
        fstart();
        send(px(100, 200, 300), "R3");
        send(px(1, 2, 1023), "R3");
        idle(5);

        // R4 and R6: RGB to limited-range BT.709
        c = '{cn(0.181873), cn(0.611831), cn(0.061765),
              cn(-0.100251), cn(-0.337249), cn(0.4375),
              cn(0.4375), cn(-0.397384), cn(-0.040116)};
        pr = '{0, 0, 0}; po = '{64, 512, 512};
        load(c, pr, po, 1'b1, 1'b0);
        fstart();
        send(px(1023, 1023, 1023), "R4");
        send(px(0, 0, 0), "R6");
        send(px(1023, 0, 0), "R4");
        send(px(0, 0, 1023), "R4");
        send(px(300, 700, 150), "R4");
        idle(5);

        // R10: junk in reserved bits and unmapped addresses
        load(c, pr, po, 1'b1, 1'b1);
        fstart();
        send(px(1023, 1023, 1023), "R10");
        send(px(512, 256, 128), "R10");
        idle(5);

        // R5: exact halves in both signs
        c = '{512, 0, 0, 0, -512, 0, 0, 0, 512};
        pr = '{0, 0, 0}; po = '{0, 100, 0};
        load(c, pr, po, 1'b1, 1'b0);
        fstart();
        send(px(1, 1, 3), "R5");
        send(px(3, 3, 5), "R5");
        send(px(0, 1023, 1), "R5");
        idle(5);

        // R7: clamp both ends
        c = '{2048, 0, 0, 0, 2048, 0, 0, 0, -1024};
        pr = '{0, -1000, 0}; po = '{0, 0, 10};
        load(c, pr, po, 1'b1, 1'b0);
        fstart();
        send(px(1000, 10, 500), "R7");
        send(px(511, 1023, 5), "R7");
        send(px(512, 1000, 0), "R7");
        idle(5);

        // R8: gapped and back-to-back traffic
        send(px(10, 20, 30), "R8");
        idle(2);
        send(px(40, 50, 60), "R8");
        send(px(70, 80, 90), "R8");
        idle(1);
        send(px(5, 6, 7), "R8");
        idle(6);

        // R2: clear the enable again
        load(c, pr, po, 1'b0, 1'b0);
        fstart();
        send(px(1000, 10, 500), "R2");
        send(px(3, 1023, 0), "R2");
        idle(6);

        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R8: results outstanding got %0d exp 0", sb.size());
        end
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog: run still active got timeout exp finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule